// File: doc/BRIEF.md
# Serial Audio Control Register Receiver

This block listens on a three-wire control bus (enable, clock and data) and turns a fixed-length control frame into the settings of an audio signal path. These settings are the input selector, a five-band equalizer and four independent attenuators: left front, left rear, right front and right rear. The three bus pins are brought into a fast system clock through a two-stage synchroniser. Data is sampled on each detected rising edge of the bus clock, while the enable line is high. The bus runs far slower than the system clock.

A frame is 48 bits long and is sent least significant bit first. The 8-bit device address comes first, followed by data bits D0 to D39 in ascending order. Nothing reaches the outputs while bits are arriving. When the enable line falls, the frame is judged. It is committed to the holding registers only when it holds exactly 48 bits, carries the device address 0x41 and has all of its test bits clear. A wrong bit count raises a one-cycle frame-error pulse. Set test bits on a frame for this device raise a one-cycle test-error pulse. A frame for another address is dropped without any pulse.

The control sequencer has four states. S_IDLE waits for the enable line. S_IDLE goes to S_RECV when enable is high, which also clears the bit count. S_RECV shifts bits and goes to S_EVAL when enable falls. S_EVAL goes to S_LOAD for an acceptable frame, and otherwise returns to S_IDLE after any error pulse. S_LOAD strobes the holding registers for one cycle and then returns to S_IDLE. Each attenuation setting is provided as a coarse 4 dB stage index and a fine 1 dB stage index.

Top module: `audctl_rx`

## Requirements
- R1: A frame is accepted only if it holds exactly 48 bits when enable falls. The first bit is address bit 0, the address value is 0x41, and data bit Dn is bit 8+n of the frame.
- R2: A 48-bit frame with any address other than 0x41 changes no output and raises no error pulse.
- R3: Bits are taken only on bus clock rising edges while enable is high. Clock edges while enable is low are not counted in the next frame.
- R4: A frame whose bit count is not 48 (including 0) is discarded and produces exactly one single-cycle pulse on `frame_err`.
- R5: A 48-bit frame for this device that has any of the test bits D36..D39 set is discarded and produces exactly one single-cycle pulse on `test_err`.
- R6: The 7-bit volume code is carried in D25..D31. Codes 0..79 mean that many dB of attenuation, code 80 is full mute, and codes above 80 are treated as 80. Each channel outputs coarse = code/4 (0..20), fine = code mod 4, and a mute flag that is set for code 80.
- R7: D33 allows the left channels to update and D32 allows the right channels. D35 selects the front attenuators and D34 selects the rear ones. A channel takes the new volume code only when both its side bit and its position bit are 1; otherwise it keeps its previous setting.
- R8: Equalizer band k (k = 0..4) takes its 4-bit code from D(5+4k)..D(8+4k). The gain in dB is 2*code-10, in the range -10..+10, and codes above 10 are treated as 10. The gain is output as 5-bit two's complement.
- R9: D0..D2 choose the input (codes 0..4 mean inputs 1..5; codes above 4 are treated as 4). D3 switches the left channel's input 5 on and D4 switches the right channel's input 5 on.
- R10: After reset, every attenuator is muted (code 80), every band is at 0 dB, input code 0 is selected, both input-5 switches are off, and no error pulse is raised.
- R11: `frame_err` and `test_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus enable line, asynchronous |
| bus_sck | input | 1 | Bus clock line, asynchronous |
| bus_sda | input | 1 | Bus data line, asynchronous |
| src_sel | output | 3 | Selected input code, 0..4 |
| src5_on_l | output | 1 | Left input 5 switch on |
| src5_on_r | output | 1 | Right input 5 switch on |
| eq_gain | output | 25 | Five 5-bit signed band gains in dB, band k at bits 5k+4..5k |
| att_coarse | output | 20 | Four 5-bit coarse indices, channel c at bits 5c+4..5c (0 LF, 1 LR, 2 RF, 3 RR) |
| att_fine | output | 8 | Four 2-bit fine indices, channel c at bits 2c+1..2c |
| att_mute | output | 4 | Per-channel full-mute flags, bit c |
| frame_err | output | 1 | One-cycle pulse for a frame with the wrong bit count |
| test_err | output | 1 | One-cycle pulse for a frame with test bits set |

## Verification
On every cycle, the assertions check the following. The two error pulses last one cycle and never overlap. A load only follows a full 48-bit count. Data does not shift while enable is low. No stored volume, band or selector code is ever outside its legal range. An attenuator that lacks its side and position enables keeps its value through a load. The bench scenarios are needed for the rest: the LSB-first bit mapping, address filtering, the exact clamp and coarse/fine arithmetic across all 128 volume codes and all 16 band codes, and the fact that bus clock edges outside enable are not counted in a frame.

// File: rtl/audctl_pkg.sv
package audctl_pkg;
    localparam int FRAME_BITS = 48;
    localparam int ADDR_BITS  = 8;
    localparam int DATA_BITS  = FRAME_BITS - ADDR_BITS;
    localparam int TEST_BITS  = 4;
    localparam int CTRL_BITS  = DATA_BITS - TEST_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS) + 1;

    localparam int SEL_BITS   = 3;
    localparam int SEL_MAX    = 4;
    localparam int SEL_LSB    = 0;
    localparam int SRC5_L_BIT = 3;
    localparam int SRC5_R_BIT = 4;

    localparam int EQ_BANDS   = 5;
    localparam int EQ_BITS    = 4;
    localparam int EQ_LSB     = 5;
    localparam int EQ_MAX     = 10;
    localparam int EQ_FLAT    = EQ_MAX / 2;
    localparam int GAIN_W     = 5;

    localparam int VOL_BITS   = 7;
    localparam int VOL_LSB    = EQ_LSB + EQ_BANDS * EQ_BITS;
    localparam int VOL_MUTE   = 80;
    localparam int FINE_W     = 2;
    localparam int COARSE_W   = VOL_BITS - FINE_W;
    localparam int NCH        = 4;

    localparam int EN_RIGHT_BIT = 32;
    localparam int EN_LEFT_BIT  = 33;
    localparam int EN_REAR_BIT  = 34;
    localparam int EN_FRONT_BIT = 35;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RECV = 2'd1,
        S_EVAL = 2'd2,
        S_LOAD = 2'd3
    } rx_state_t;

    function automatic logic [VOL_BITS-1:0] clamp_vol(input logic [VOL_BITS-1:0] v);
        return (v > VOL_BITS'(VOL_MUTE)) ? VOL_BITS'(VOL_MUTE) : v;
    endfunction

    function automatic logic [EQ_BITS-1:0] clamp_eq(input logic [EQ_BITS-1:0] v);
        return (v > EQ_BITS'(EQ_MAX)) ? EQ_BITS'(EQ_MAX) : v;
    endfunction

    function automatic logic [SEL_BITS-1:0] clamp_sel(input logic [SEL_BITS-1:0] v);
        return (v > SEL_BITS'(SEL_MAX)) ? SEL_BITS'(SEL_MAX) : v;
    endfunction
endpackage

// File: rtl/audctl_sync.sv
module audctl_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] pin_raw,
    output logic       en_lvl,
    output logic       en_fall,
    output logic       sck_rise,
    output logic       sda_lvl
);
    logic [STAGES-1:0] chain [3];
    logic              sck_lvl;
    logic              en_d;
    logic              sck_d;

    for (genvar p = 0; p < 3; p++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[p] <= '0;
            end else begin
                chain[p] <= {chain[p][STAGES-2:0], pin_raw[p]};
            end
        end
    end

    assign en_lvl  = chain[0][STAGES-1];
    assign sck_lvl = chain[1][STAGES-1];
    assign sda_lvl = chain[2][STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_d  <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            en_d  <= en_lvl;
            sck_d <= sck_lvl;
        end
    end

    assign en_fall  = en_d & ~en_lvl;
    assign sck_rise = sck_lvl & ~sck_d;
endmodule

// File: rtl/audctl_frame_fsm.sv
module audctl_frame_fsm
    import audctl_pkg::*;
#(
    parameter logic [ADDR_BITS-1:0] DEV_ADDR = 8'h41
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_lvl,
    input  logic                 en_fall,
    input  logic                 sck_rise,
    input  logic                 sda_lvl,
    output logic                 load_stb,
    output logic [CTRL_BITS-1:0] ctrl_word,
    output logic                 frame_err,
    output logic                 test_err
);
    rx_state_t              state, nxt;
    logic [FRAME_BITS-1:0]  shreg;
    logic [CNT_W-1:0]       bit_cnt;
    logic                   len_ok;
    logic                   addr_ok;
    logic                   test_clr;

    assign len_ok   = (bit_cnt == CNT_W'(FRAME_BITS));
    assign addr_ok  = (shreg[ADDR_BITS-1:0] == DEV_ADDR);
    assign test_clr = (shreg[FRAME_BITS-1 -: TEST_BITS] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (en_lvl) nxt = S_RECV;
            S_RECV: if (en_fall) nxt = S_EVAL;
            S_EVAL: nxt = (len_ok && addr_ok && test_clr) ? S_LOAD : S_IDLE;
            S_LOAD: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            frame_err <= 1'b0;
            test_err  <= 1'b0;
        end else begin
            frame_err <= 1'b0;
            test_err  <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (en_lvl) bit_cnt <= '0;
                end
                S_RECV: begin
                    if (sck_rise && en_lvl) begin
                        shreg <= {sda_lvl, shreg[FRAME_BITS-1:1]};
                        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                S_EVAL: begin
                    if (!len_ok) begin
                        frame_err <= 1'b1;
                    end else if (addr_ok && !test_clr) begin
                        test_err <= 1'b1;
                    end
                end
                S_LOAD: begin
                end
            endcase
        end
    end

    assign load_stb  = (state == S_LOAD);
    assign ctrl_word = shreg[ADDR_BITS +: CTRL_BITS];

    // R4: a length error is a single-cycle pulse
    p_len_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);
    // R5: a test-bit error is a single-cycle pulse
    p_test_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        test_err |=> !test_err);
    // R11: the two error outputs never coincide
    p_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err && test_err));
    // R1: a load is only ever issued for a full-length frame of this device
    p_load_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (len_ok && addr_ok));
    // R3: no data moves into the shift register while enable is low
    p_no_shift_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_lvl |=> $stable(shreg));
endmodule

// File: rtl/audctl_decode.sv
module audctl_decode
    import audctl_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_stb,
    input  logic [CTRL_BITS-1:0]         ctrl_word,
    output logic [SEL_BITS-1:0]          src_sel,
    output logic                         src5_on_l,
    output logic                         src5_on_r,
    output logic [EQ_BANDS*GAIN_W-1:0]   eq_gain,
    output logic [NCH*COARSE_W-1:0]      att_coarse,
    output logic [NCH*FINE_W-1:0]        att_fine,
    output logic [NCH-1:0]               att_mute
);
    logic [EQ_BITS-1:0]  eq_q  [EQ_BANDS];
    logic [VOL_BITS-1:0] vol_q [NCH];
    logic [VOL_BITS-1:0] vol_new;

    assign vol_new = clamp_vol(ctrl_word[VOL_LSB +: VOL_BITS]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel   <= '0;
            src5_on_l <= 1'b0;
            src5_on_r <= 1'b0;
        end else if (load_stb) begin
            src_sel   <= clamp_sel(ctrl_word[SEL_LSB +: SEL_BITS]);
            src5_on_l <= ctrl_word[SRC5_L_BIT];
            src5_on_r <= ctrl_word[SRC5_R_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            p_sel_legal_r9: assert (src_sel <= SEL_BITS'(SEL_MAX));
        end
    end

    for (genvar k = 0; k < EQ_BANDS; k++) begin : g_band
        logic [GAIN_W:0] twice;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                eq_q[k] <= EQ_BITS'(EQ_FLAT);
            end else if (load_stb) begin
                eq_q[k] <= clamp_eq(ctrl_word[EQ_LSB + k*EQ_BITS +: EQ_BITS]);
            end
        end
        assign twice = {1'b0, eq_q[k], 1'b0} - (GAIN_W+1)'(EQ_MAX);
        assign eq_gain[k*GAIN_W +: GAIN_W] = twice[GAIN_W-1:0];

        // R8: a stored band code never exceeds the top setting
        p_eq_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
            eq_q[k] <= EQ_BITS'(EQ_MAX));
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int SIDE_BIT = (c < 2) ? EN_LEFT_BIT : EN_RIGHT_BIT;
        localparam int POS_BIT  = (c % 2 == 1) ? EN_REAR_BIT : EN_FRONT_BIT;
        logic take;
        assign take = load_stb && ctrl_word[SIDE_BIT] && ctrl_word[POS_BIT];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vol_q[c] <= VOL_BITS'(VOL_MUTE);
            end else if (take) begin
                vol_q[c] <= vol_new;
            end
        end
        assign att_coarse[c*COARSE_W +: COARSE_W] = vol_q[c][VOL_BITS-1:FINE_W];
        assign att_fine[c*FINE_W +: FINE_W]       = vol_q[c][FINE_W-1:0];
        assign att_mute[c]                        = (vol_q[c] == VOL_BITS'(VOL_MUTE));

        // R7: without both of its enables a channel keeps its volume through a load
        p_vol_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(load_stb && ctrl_word[SIDE_BIT] && ctrl_word[POS_BIT]) |=> $stable(vol_q[c]));
        // R6: a stored volume code never passes the mute code
        p_vol_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
            vol_q[c] <= VOL_BITS'(VOL_MUTE));
    end
endmodule

// File: rtl/audctl_rx.sv
module audctl_rx
    import audctl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR    = 8'h41,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_sck,
    input  logic        bus_sda,
    output logic [2:0]  src_sel,
    output logic        src5_on_l,
    output logic        src5_on_r,
    output logic [24:0] eq_gain,
    output logic [19:0] att_coarse,
    output logic [7:0]  att_fine,
    output logic [3:0]  att_mute,
    output logic        frame_err,
    output logic        test_err
);
    logic                 en_lvl;
    logic                 en_fall;
    logic                 sck_rise;
    logic                 sda_lvl;
    logic                 load_stb;
    logic [CTRL_BITS-1:0] ctrl_word;

    audctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  ({bus_sda, bus_sck, bus_en}),
        .en_lvl   (en_lvl),
        .en_fall  (en_fall),
        .sck_rise (sck_rise),
        .sda_lvl  (sda_lvl)
    );

    audctl_frame_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_lvl    (en_lvl),
        .en_fall   (en_fall),
        .sck_rise  (sck_rise),
        .sda_lvl   (sda_lvl),
        .load_stb  (load_stb),
        .ctrl_word (ctrl_word),
        .frame_err (frame_err),
        .test_err  (test_err)
    );

    audctl_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_stb   (load_stb),
        .ctrl_word  (ctrl_word),
        .src_sel    (src_sel),
        .src5_on_l  (src5_on_l),
        .src5_on_r  (src5_on_r),
        .eq_gain    (eq_gain),
        .att_coarse (att_coarse),
        .att_fine   (att_fine),
        .att_mute   (att_mute)
    );
endmodule

// File: tb/tb_audctl_rx.sv
module tb_audctl_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_sck = 1'b0;
    logic        bus_sda = 1'b0;
    logic [2:0]  src_sel;
    logic        src5_on_l, src5_on_r;
    logic [24:0] eq_gain;
    logic [19:0] att_coarse;
    logic [7:0]  att_fine;
    logic [3:0]  att_mute;
    logic        frame_err, test_err;

    int vectors = 0;
    int errors  = 0;
    int fe_seen = 0, te_seen = 0, both_seen = 0;
    int fe_exp  = 0, te_exp  = 0;
    bit done = 1'b0;

    int m_sel, m_l5, m_r5;
    int m_eq  [5];
    int m_vol [4];

    always #5 clk = ~clk;

    audctl_rx dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_sck(bus_sck), .bus_sda(bus_sda),
        .src_sel(src_sel), .src5_on_l(src5_on_l), .src5_on_r(src5_on_r),
        .eq_gain(eq_gain), .att_coarse(att_coarse), .att_fine(att_fine),
        .att_mute(att_mute), .frame_err(frame_err), .test_err(test_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_err) fe_seen++;
            if (test_err) te_seen++;
            if (frame_err && test_err) both_seen++;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "src_sel", int'(src_sel), m_sel);
        chk(tag, "src5_on_l", int'(src5_on_l), m_l5);
        chk(tag, "src5_on_r", int'(src5_on_r), m_r5);
        for (int k = 0; k < 5; k++)
            chk(tag, $sformatf("eq_gain[%0d]", k), int'(eq_gain[k*5 +: 5]),
                (2 * m_eq[k] - 10) & 31);
        for (int c = 0; c < 4; c++) begin
            chk(tag, $sformatf("att_coarse[%0d]", c), int'(att_coarse[c*5 +: 5]), m_vol[c] / 4);
            chk(tag, $sformatf("att_fine[%0d]", c), int'(att_fine[c*2 +: 2]), m_vol[c] % 4);
            chk(tag, $sformatf("att_mute[%0d]", c), int'(att_mute[c]), (m_vol[c] == 80) ? 1 : 0);
        end
        chk(tag, "frame_err count", fe_seen, fe_exp);
        chk(tag, "test_err count", te_seen, te_exp);
    endtask

    function automatic logic [39:0] mkdata(input int sel, input int l5, input int r5,
                                           input logic [19:0] eqs, input int vol,
                                           input logic [3:0] en, input logic [3:0] tst);
        logic [39:0] d = '0;
        d[2:0]   = 3'(sel);
        d[3]     = 1'(l5);
        d[4]     = 1'(r5);
        d[24:5]  = eqs;
        d[31:25] = 7'(vol);
        d[35:32] = en;
        d[39:36] = tst;
        return d;
    endfunction

    // Model of a committed frame: R6..R9 field layout and clamps
    task automatic model_commit(input logic [39:0] d);
        int v;
        m_sel = (int'(d[2:0]) > 4) ? 4 : int'(d[2:0]);
        m_l5  = int'(d[3]);
        m_r5  = int'(d[4]);
        for (int k = 0; k < 5; k++) begin
            m_eq[k] = int'(d[5 + 4*k +: 4]);
            if (m_eq[k] > 10) m_eq[k] = 10;
        end
        v = int'(d[31:25]);
        if (v > 80) v = 80;
        if (d[33] && d[35]) m_vol[0] = v;
        if (d[33] && d[34]) m_vol[1] = v;
        if (d[32] && d[35]) m_vol[2] = v;
        if (d[32] && d[34]) m_vol[3] = v;
    endtask

    task automatic send(input logic [7:0] addr, input logic [39:0] data, input int nbits);
        logic [47:0] f;
        f = {data, addr};
        @(negedge clk);
        bus_en = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            bus_sda = (i < 48) ? f[i] : 1'b0;
            repeat (4) @(negedge clk);
            bus_sck = 1'b1;
            repeat (4) @(negedge clk);
            bus_sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        bus_en = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic send_ok(input logic [39:0] d);
        send(8'h41, d, 48);
        model_commit(d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [19:0] eqs;
        logic [19:0] flat;
        flat = {5{4'd5}};
        m_sel = 0; m_l5 = 0; m_r5 = 0;
        for (int k = 0; k < 5; k++) m_eq[k] = 5;
        for (int c = 0; c < 4; c++) m_vol[c] = 80;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R10");

        // R1: distinct fields in one frame, LSB-first mapping
        send_ok(mkdata(2, 1, 0, {4'd1, 4'd9, 4'd3, 4'd7, 4'd0}, 37, 4'b1111, 4'b0000));
        check_all("R1");

        // R9: every selector code and switch combination
        for (int s = 0; s < 8; s++) begin
            send_ok(mkdata(s, s & 1, (s >> 1) & 1, flat, 0, 4'b0000, 4'b0000));
            check_all("R9");
        end

        // R8: every band code, bands offset from each other
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 5; k++) eqs[k*4 +: 4] = 4'((c + 3*k) % 16);
            send_ok(mkdata(0, 0, 0, eqs, 0, 4'b0000, 4'b0000));
            check_all("R8");
        end

        // R6: every volume code on all four channels
        for (int v = 0; v < 128; v++) begin
            send_ok(mkdata(1, 0, 1, flat, v, 4'b1111, 4'b0000));
            check_all("R6");
        end

        // R7: every combination of side and position enables
        for (int e = 0; e < 16; e++) begin
            send_ok(mkdata(0, 0, 0, flat, 5 * e + 2, 4'(e), 4'b0000));
            check_all("R7");
        end

        // R2: foreign addresses change nothing and raise nothing
        send(8'h82, mkdata(3, 1, 1, 20'h0, 11, 4'b1111, 4'b0000), 48); check_all("R2");
        send(8'h40, mkdata(3, 1, 1, 20'h0, 12, 4'b1111, 4'b0000), 48); check_all("R2");
        send(8'hC1, mkdata(3, 1, 1, 20'h0, 13, 4'b1111, 4'b0000), 48); check_all("R2");
        send(8'h00, mkdata(3, 1, 1, 20'h0, 14, 4'b1111, 4'b1111), 48); check_all("R2");

        // R4: wrong lengths discarded, one pulse each
        send(8'h41, mkdata(4, 1, 1, 20'h0, 21, 4'b1111, 4'b0000), 47); fe_exp++; check_all("R4");
        send(8'h41, mkdata(4, 1, 1, 20'h0, 22, 4'b1111, 4'b0000), 49); fe_exp++; check_all("R4");
        send(8'h41, mkdata(4, 1, 1, 20'h0, 23, 4'b1111, 4'b0000), 0);  fe_exp++; check_all("R4");
        send(8'h41, mkdata(4, 1, 1, 20'h0, 24, 4'b1111, 4'b0000), 1);  fe_exp++; check_all("R4");

        // R5: each test bit alone rejects the frame
        for (int t = 0; t < 4; t++) begin
            send(8'h41, mkdata(4, 1, 1, 20'h0, 30 + t, 4'b1111, 4'(1 << t)), 48);
            te_exp++;
            check_all("R5");
        end

        // R3: clock edges while enable is low are not part of the next frame
        for (int i = 0; i < 5; i++) begin
            bus_sda = 1'b1;
            repeat (4) @(negedge clk); bus_sck = 1'b1;
            repeat (4) @(negedge clk); bus_sck = 1'b0;
        end
        repeat (10) @(negedge clk);
        check_all("R3");
        send_ok(mkdata(3, 0, 1, {4'd2, 4'd4, 4'd6, 4'd8, 4'd10}, 45, 4'b1111, 4'b0000));
        check_all("R3");

        // R11: the two error pulses never overlapped
        chk("R11", "simultaneous error pulses", both_seen, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule